// File: doc/BRIEF.md
# Conversion Cycle Sequencer

This block times one acquisition-and-conversion cycle of a sampling converter. It runs on the converter clock and divides that clock by a programmable factor of 1, 2, 4 or 8 to form conversion ticks. One cycle is 50 ticks long. The first 36 ticks form the amplifier phase, which covers capture, auto-zero, level shift and gain. The last 14 ticks form the successive-approximation phase, which resolves one result bit per tick.

A cycle can be requested in three ways: a one-cycle strobe from the serial command decoder, a one-cycle strobe when a register start bit is latched, or a rising edge on the external convert pin. The convert pin is sampled on the converter clock and must already be synchronous to it. Every request is aligned so that the cycle begins on the second converter-clock edge after the edge that sampled it. The pin edge must also meet its pulse-width rules.

While a cycle runs, `busy` is high and the phase enables and the bit index steer the analog section. A host waits for `busy` to fall, or for the `done` pulse, before it reads the result. Requests that arrive during alignment or while `busy` is high are dropped. All control pins are plain levels or strobes; the block has no data stream and no handshake.

Top module: `cnv_cycle_seq`

## Requirements
- R1: A request sampled at converter-clock edge k makes `busy` rise at edge k+2, with `amp_en` high in the first busy cycle.
- R2: `busy` stays high for exactly 50×F converter-clock cycles, where F is 1, 2, 4 or 8 for `div_sel` values 0, 1, 2 and 3.
- R3: While busy, exactly one of `amp_en` and `sar_en` is high. `amp_en` covers the first 36×F cycles and `sar_en` the last 14×F cycles.
- R4: During the SAR phase, `sar_bit` starts at 13 and steps down by one every F cycles, ending at 0. Outside the SAR phase it reads 0.
- R5: `done` is high for exactly one cycle, the first cycle after `busy` falls, and is never high while `busy` is high.
- R6: `cmd_start`, `reg_start` and a qualified rising edge on `cnv_pin` all start an identical cycle.
- R7: A rising edge on `cnv_pin` counts only if the pin was sampled low on at least the two previous edges.
- R8: A pin start is abandoned if `cnv_pin` is sampled low on the edge after the rising edge. The pin must be high for at least two samples.
- R9: Requests of any source are ignored while `busy` is high and during the two alignment cycles.
- R10: `div_sel` is captured when the cycle starts, so changing it during a cycle does not change that cycle's length.
- R11: After reset, `busy`, `amp_en`, `sar_en`, `done` and `sar_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 2 | Clock divide select: F = 2^div_sel |
| cmd_start | input | 1 | Start strobe from serial command decode |
| reg_start | input | 1 | Start strobe when the register start bit is latched |
| cnv_pin | input | 1 | External convert pin, synchronous to clk |
| busy | output | 1 | High for the whole conversion cycle |
| amp_en | output | 1 | Amplifier phase enable |
| sar_en | output | 1 | Successive-approximation phase enable |
| sar_bit | output | 4 | Index of the bit being resolved, 13 down to 0 |
| done | output | 1 | One-cycle pulse at the end of the cycle |

## Verification
The main cycle is run from each of the three start sources across all four divide settings. Pin pulses are held high for one, two and three samples, which separates the alignment latency from the divider length and from the phase split. A start inside the alignment window, starts during busy, and a mid-cycle change of the divide select show whether requests and settings leak into a running cycle. Pin sequences with a one-sample high, a one-sample low gap, and a two-sample low gap separate the rules for minimum high time and minimum low time.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [1:0] {
    AL_IDLE  = 2'd0,
    AL_WAIT1 = 2'd1,
    AL_WAIT2 = 2'd2
  } align_t;
endpackage

// File: rtl/cseq_start_align.sv
module cseq_start_align
  import cseq_pkg::*;
#(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic reg_start,
  input  logic cnv_pin,
  input  logic busy,
  output logic launch
);
  localparam int LW = $clog2(MIN_LOW + 1);

  align_t        state;
  logic [LW-1:0] lo_cnt;
  logic          pin_only;
  logic          pin_rise;
  logic          accept;

  // count consecutive low samples of the pin, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
    end else if (cnv_pin) begin
      lo_cnt <= '0;
    end else if (lo_cnt < LW'(MIN_LOW)) begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assign pin_rise = cnv_pin && (lo_cnt >= LW'(MIN_LOW));
  assign accept   = (state == AL_IDLE) && !busy && (cmd_start || reg_start || pin_rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= AL_IDLE;
      pin_only <= 1'b0;
    end else begin
      case (state)
        AL_IDLE: if (accept) begin
          state    <= AL_WAIT1;
          pin_only <= !(cmd_start || reg_start);
        end
        AL_WAIT1: state <= (pin_only && !cnv_pin) ? AL_IDLE : AL_WAIT2;
        AL_WAIT2: state <= AL_IDLE;
        default:  state <= AL_IDLE;
      endcase
    end
  end

  assign launch = (state == AL_WAIT2);

  a_r9_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state == AL_IDLE));
  a_r8_pin_held: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && pin_only) |-> $past(cnv_pin));
  a_r7_pin_low_before: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AL_WAIT1 && pin_only) |-> ($past(cnv_pin, 2) == 1'b0));
endmodule

// File: rtl/cseq_div.sv
module cseq_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAXLOG = (1 << SEL_W) - 1;
  localparam int CW     = (MAXLOG < 1) ? 1 : MAXLOG;

  logic [CW-1:0] cnt;
  logic [CW:0]   span;
  logic [CW-1:0] last_v;

  always_comb begin
    span   = {{CW{1'b0}}, 1'b1} << sel;
    last_v = CW'(span - 1'b1);
  end

  assign tick = (cnt == last_v);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && !restart) |=> !tick);
endmodule

// File: rtl/cseq_phase.sv
module cseq_phase #(
  parameter int AMP_TICKS = 36,
  parameter int SAR_BITS  = 14,
  parameter int SEL_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic                        tick,
  input  logic [SEL_W-1:0]            div_sel_in,
  output logic [SEL_W-1:0]            sel_q,
  output logic                        busy,
  output logic                        amp_en,
  output logic                        sar_en,
  output logic [$clog2(SAR_BITS)-1:0] sar_bit,
  output logic                        done
);
  localparam int TOTAL = AMP_TICKS + SAR_BITS;
  localparam int PW    = $clog2(TOTAL);
  localparam int BW    = $clog2(SAR_BITS);
  localparam logic [PW-1:0] LAST_P = PW'(TOTAL - 1);
  localparam logic [PW-1:0] AMP_P  = PW'(AMP_TICKS);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pcnt  <= '0;
      sel_q <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy  <= 1'b1;
        pcnt  <= '0;
        sel_q <= div_sel_in;
      end else if (busy && tick) begin
        if (pcnt == LAST_P) begin
          busy <= 1'b0;
          done <= 1'b1;
          pcnt <= '0;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end

  assign remain  = LAST_P - pcnt;
  assign amp_en  = busy && (pcnt < AMP_P);
  assign sar_en  = busy && !(pcnt < AMP_P);
  assign sar_bit = sar_en ? BW'(remain) : '0;

  a_r5_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_amp_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> amp_en);
  a_r3_sar_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(sar_en) && $past(sar_bit) == '0));
  a_r4_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sar_en && $past(sar_en) && sar_bit != $past(sar_bit)) |-> ((sar_bit + 1'b1) == $past(sar_bit)));
  a_r10_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !launch) |-> $stable(sel_q));
endmodule

// File: rtl/cnv_cycle_seq.sv
module cnv_cycle_seq #(
  parameter int AMP_TICKS = 36,
  parameter int SAR_BITS  = 14,
  parameter int SEL_W     = 2,
  parameter int MIN_LOW   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SEL_W-1:0]            div_sel,
  input  logic                        cmd_start,
  input  logic                        reg_start,
  input  logic                        cnv_pin,
  output logic                        busy,
  output logic                        amp_en,
  output logic                        sar_en,
  output logic [$clog2(SAR_BITS)-1:0] sar_bit,
  output logic                        done
);
  logic             launch;
  logic             tick;
  logic [SEL_W-1:0] sel_q;

  cseq_start_align #(.MIN_LOW(MIN_LOW)) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .reg_start (reg_start),
    .cnv_pin   (cnv_pin),
    .busy      (busy),
    .launch    (launch)
  );

  cseq_div #(.SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (launch),
    .sel     (sel_q),
    .tick    (tick)
  );

  cseq_phase #(
    .AMP_TICKS (AMP_TICKS),
    .SAR_BITS  (SAR_BITS),
    .SEL_W     (SEL_W)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .tick       (tick),
    .div_sel_in (div_sel),
    .sel_q      (sel_q),
    .busy       (busy),
    .amp_en     (amp_en),
    .sar_en     (sar_en),
    .sar_bit    (sar_bit),
    .done       (done)
  );

  a_r1_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && amp_en));
  a_r9_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
endmodule

// File: tb/sim_cnv_cycle_seq.sv
module sim_cnv_cycle_seq;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       cmd_start = 1'b0;
  logic       reg_start = 1'b0;
  logic       cnv_pin = 1'b0;
  logic       busy, amp_en, sar_en, done;
  logic [3:0] sar_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // vector: {src[1:0], sel[1:0], hold[1:0]}; src 0=cmd 1=reg 2=pin
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 2'd0, 2'd1}, {2'd1, 2'd1, 2'd1}, {2'd2, 2'd2, 2'd2}, {2'd0, 2'd3, 2'd1},
    {2'd2, 2'd0, 2'd3}, {2'd1, 2'd3, 2'd1}, {2'd2, 2'd1, 2'd2}, {2'd0, 2'd2, 2'd1}
  };

  always #(CLK_P/2) clk = ~clk;

  cnv_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cmd_start(cmd_start),
    .reg_start(reg_start), .cnv_pin(cnv_pin), .busy(busy), .amp_en(amp_en),
    .sar_en(sar_en), .sar_bit(sar_bit), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int src, input int hold);
    @(negedge clk);
    case (src)
      0: cmd_start = 1'b1;
      1: reg_start = 1'b1;
      default: cnv_pin = 1'b1;
    endcase
    repeat (hold) @(negedge clk);
    cmd_start = 1'b0;
    reg_start = 1'b0;
    cnv_pin   = 1'b0;
  endtask

  task automatic count_busy(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) hits++;
    end
  endtask

  // measure a cycle from the current negedge
  task automatic measure(output int wt, output int nb, output int na, output int ns,
                         output int first, output int last, output int chg,
                         output int dbad, output int dend);
    int prev;
    wt = 0; nb = 0; na = 0; ns = 0; first = -1; last = -1; chg = 0; dbad = 0; prev = 0;
    while (!busy && wt < 20) begin
      wt++;
      @(negedge clk);
    end
    while (busy && nb < 2000) begin
      nb++;
      if (amp_en) na++;
      if (sar_en) begin
        if (ns == 0) first = sar_bit;
        else if (sar_bit != prev) chg++;
        prev = sar_bit;
        last = sar_bit;
        ns++;
      end
      if (done) dbad++;
      @(negedge clk);
    end
    dend = done;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int wt, nb, na, ns, first, last, chg, dbad, dend, hits;
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 busy", busy, 0);
    check("R11 amp_en", amp_en, 0);
    check("R11 sar_en", sar_en, 0);
    check("R11 done", done, 0);
    check("R11 sar_bit", sar_bit, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 busy after release", busy, 0);

    // table-driven cycles, R1..R6
    for (int v = 0; v < 8; v++) begin
      int src, sel, hold, f;
      src  = VEC[v][5:4];
      sel  = VEC[v][3:2];
      hold = VEC[v][1:0];
      f    = 1 << sel;
      div_sel = sel[1:0];
      repeat (4) @(negedge clk);
      pulse(src, hold);
      measure(wt, nb, na, ns, first, last, chg, dbad, dend);
      check($sformatf("R1 R6 src%0d start delay", src), wt, (hold >= 3) ? 0 : 3 - hold);
      check($sformatf("R2 R6 src%0d busy length sel%0d", src, sel), nb, 50 * f);
      check("R3 amp length", na, 36 * f);
      check("R3 sar length", ns, 14 * f);
      check("R4 first bit", first, 13);
      check("R4 last bit", last, 0);
      check("R4 bit steps", chg, 13);
      check("R5 no done while busy", dbad, 0);
      check("R5 done at end", dend, 1);
      @(negedge clk);
      check("R5 done single cycle", done, 0);
    end

    // R9: second request inside the alignment window
    div_sel = 2'd0;
    repeat (4) @(negedge clk);
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0; reg_start = 1'b1;
    @(negedge clk); reg_start = 1'b0;
    measure(wt, nb, na, ns, first, last, chg, dbad, dend);
    check("R9 align window delay", wt, 1);
    check("R9 align window length", nb, 50);
    count_busy(10, hits);
    check("R9 no second cycle after align request", hits, 0);

    // R9: requests during busy
    div_sel = 2'd1;
    pulse(0, 1);
    while (!busy) @(negedge clk);
    nb = 0;
    for (int i = 0; i < 20; i++) begin if (busy) nb++; @(negedge clk); end
    cmd_start = 1'b1; if (busy) nb++; @(negedge clk);
    cmd_start = 1'b0; reg_start = 1'b1; if (busy) nb++; @(negedge clk);
    reg_start = 1'b0; cnv_pin = 1'b1; if (busy) nb++;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (busy) nb++; end
    cnv_pin = 1'b0;
    @(negedge clk);
    while (busy) begin nb++; @(negedge clk); end
    check("R9 busy length with requests", nb, 100);
    count_busy(12, hits);
    check("R9 requests during busy dropped", hits, 0);

    // R8: pin high for one sample only
    div_sel = 2'd0;
    repeat (4) @(negedge clk);
    pulse(2, 1);
    count_busy(10, hits);
    check("R8 short pin pulse dropped", hits, 0);

    // R7: pin high held through a cycle, then a one-sample low gap
    pulse(0, 1);
    cnv_pin = 1'b1;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    cnv_pin = 1'b0;
    @(negedge clk);
    cnv_pin = 1'b1;
    count_busy(10, hits);
    check("R7 one-sample low gap rejected", hits, 0);
    cnv_pin = 1'b0;
    repeat (2) @(negedge clk);
    cnv_pin = 1'b1;
    repeat (3) @(negedge clk);
    cnv_pin = 1'b0;
    count_busy(50, hits);
    check("R7 two-sample low gap accepted", hits, 50 - 1);

    // R10: divide select changed mid-cycle
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    div_sel = 2'd1;
    pulse(0, 1);
    while (!busy) @(negedge clk);
    nb = 0;
    while (busy && nb < 2000) begin
      nb++;
      if (nb == 10) div_sel = 2'd3;
      @(negedge clk);
    end
    check("R10 length uses captured select", nb, 100);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule